// File: doc/BRIEF.md
# Parallel Byte Stream Receiver with Hysteretic Flow Control

This block accepts a byte-wide parallel stream from an external sender and places each byte into a 256-entry on-chip receive buffer. A byte is taken on every rising edge of the stream clock during which the valid strobe is at its active level. If the start strobe is also active on that edge, the byte is stored with a tag bit. The tag marks the byte as the first byte of a packet. The consumer reads bytes through a simple pop port. Read data is registered. The port also gives an empty flag and a count of free entries.

The stream clock has two sources, chosen by a configuration input. It can come in from the sender, or the block can generate it by dividing the core clock. In the second case the block drives the clock out with an output enable. The whole design runs in one core clock domain. An external stream clock is sampled as a level, and the block detects its rising edges.

A request line tells the sender to pause, and it uses wide hysteresis. The request turns on when 8 or fewer entries are free. This leaves room for the 8 bytes a sender may still deliver after it sees the request. The request turns off only when 192 or more entries are free. The start, valid and request lines each have their own active-level setting. A separate enable decides whether the request line is used at all.

Top module: `strm_rx`

## Requirements
- R1: With the external clock source selected (`cfg_clk_int`=0), the block stores one byte on each core-clock edge at which `strm_clk_i` is seen high after being low in the previous cycle, provided the valid strobe is active on that edge. The free count drops by one in the following cycle.
- R2: With the internal source selected (`cfg_clk_int`=1), `strm_clk_oe` is 1 and `strm_clk_o` toggles every `CLK_HALF` core cycles, giving a rising edge every 2*`CLK_HALF` cycles. A byte is captured at the core edge where `strm_clk_o` rises. With the external source selected, `strm_clk_oe` and `strm_clk_o` are 0.
- R3: The start and valid strobes are active when the pin equals its polarity input (`cfg_start_pol`, `cfg_valid_pol`: 1 means active high). When valid is inactive, a stream clock edge stores nothing.
- R4: Each stored entry is 9 bits. Bit 8 is the start tag and bits 7:0 are the data byte.
- R5: When the free count is 8 or less, the internal request state is set in the following cycle. The 8 bytes that arrive after that are all stored.
- R6: The request state clears in the cycle after the free count reaches 192 or more. While the free count is between 9 and 191, the state keeps its previous value.
- R7: With `cfg_req_en`=1, `strm_req_o` equals `cfg_req_pol` while the request state is set and its inverse otherwise. With `cfg_req_en`=0, `strm_req_o` is fixed at the inverse of `cfg_req_pol`.
- R8: Bytes are read in arrival order. A pop with `rd_en_i`=1 on a non-empty buffer presents the oldest entry on `rd_data_o` from the next cycle. `rd_free_o` is 256 minus the number of stored entries, and `rd_empty_o` is 1 exactly when no entries are stored.
- R9: A byte arriving while the buffer is full is dropped, and `ovf_o` is set from the next cycle. `ovf_o` stays set until `ovf_clr_i` is applied. If a drop and a clear happen in the same cycle, the flag stays set.
- R10: A pop on an empty buffer does nothing: `rd_data_o`, `rd_free_o` and `rd_empty_o` stay unchanged.
- R11: After reset, the buffer is empty (`rd_free_o`=256), `ovf_o` is 0 and the request state is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_int | input | 1 | 1: generate stream clock internally; 0: use strm_clk_i |
| cfg_start_pol | input | 1 | Active level of the start strobe |
| cfg_valid_pol | input | 1 | Active level of the valid strobe |
| cfg_req_pol | input | 1 | Active level of the request output |
| cfg_req_en | input | 1 | Enables request flow control |
| strm_clk_i | input | 1 | External stream clock |
| strm_clk_o | output | 1 | Generated stream clock |
| strm_clk_oe | output | 1 | Output enable for the generated stream clock |
| strm_start_i | input | 1 | Packet start strobe |
| strm_valid_i | input | 1 | Data valid strobe |
| strm_data_i | input | 8 | Stream data byte |
| strm_req_o | output | 1 | Flow-control request to the sender |
| rd_en_i | input | 1 | Pop request |
| rd_data_o | output | 9 | Popped entry {start tag, byte} |
| rd_empty_o | output | 1 | Buffer empty |
| rd_free_o | output | 9 | Number of free entries |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |

## Verification
A wrong occupancy count appears on `rd_free_o` and `rd_empty_o` in the cycle after the push or pop that caused it. It also moves the request threshold crossings, so `strm_req_o` comes out one or more cycles early or late. A wrong read or write pointer does not show up until the affected entry is popped, and then `rd_data_o` carries the wrong byte or tag. A lost edge in the stream-clock detector or divider appears as a missing or extra decrement of the free count in the cycle after the edge. The reference model in the bench tracks all of these on every cycle, so any of these faults is reported within one cycle of becoming visible at the ports.

// File: rtl/strm_rx_pkg.sv
package strm_rx_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ENTRY_W = BYTE_W + 1;

  typedef enum logic {
    CLK_SRC_EXT = 1'b0,
    CLK_SRC_INT = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic              first;
    logic [BYTE_W-1:0] data;
  } entry_t;

endpackage

// File: rtl/strm_rx_clkgen.sv
module strm_rx_clkgen #(
  parameter int unsigned CLK_HALF = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_int_i,
  input  logic ext_clk_i,
  output logic tick_o,
  output logic clk_o,
  output logic clk_oe_o
);
  import strm_rx_pkg::*;

  localparam int unsigned CW = (CLK_HALF > 2) ? $clog2(CLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

  clk_src_e        src;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            gen_q, gen_d;
  logic            ext_prev_q;
  logic            wrap;
  logic            ext_rise;
  logic            int_rise;

  assign src      = clk_src_e'(src_int_i);
  assign wrap     = (cnt_q == LAST);
  assign ext_rise = ext_clk_i & ~ext_prev_q;
  assign int_rise = wrap & ~gen_q;

  always_comb begin
    cnt_d = cnt_q;
    gen_d = gen_q;
    if (src == CLK_SRC_INT) begin
      if (wrap) begin
        cnt_d = '0;
        gen_d = ~gen_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
      gen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      gen_q      <= 1'b0;
      ext_prev_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      gen_q      <= gen_d;
      ext_prev_q <= ext_clk_i;
    end
  end

  assign tick_o   = (src == CLK_SRC_INT) ? int_rise : ext_rise;
  assign clk_o    = gen_q;
  assign clk_oe_o = (src == CLK_SRC_INT);

endmodule

// File: rtl/strm_rx_capture.sv
module strm_rx_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_pol_i,
  input  logic              valid_pol_i,
  output logic              push_o,
  output logic [DATA_W:0]   wdata_o
);

  logic start_act;
  logic valid_act;

  assign start_act = ~(start_i ^ start_pol_i);
  assign valid_act = ~(valid_i ^ valid_pol_i);

  assign push_o  = tick_i & valid_act;
  assign wdata_o = {start_act, data_i};

endmodule

// File: rtl/strm_rx_fifo.sv
module strm_rx_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [WIDTH-1:0]             wdata_i,
  input  logic                         pop_i,
  input  logic                         ovf_clr_i,
  output logic [WIDTH-1:0]             rdata_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         ovf_o
);

  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic [WIDTH-1:0] rdata_q;
  logic             ovf_q, ovf_d;
  logic             wr_go;
  logic             rd_go;
  logic             drop;

  assign full_o  = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign wr_go   = push_i & ~full_o;
  assign drop    = push_i & full_o;
  assign rd_go   = pop_i & ~empty_o;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    if (wr_go) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (rd_go) begin
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({wr_go, rd_go})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (drop) begin
      ovf_d = 1'b1;
    end else if (ovf_clr_i) begin
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
      if (rd_go) begin
        rdata_q <= mem[rd_ptr_q];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      mem[wr_ptr_q] <= wdata_i;
    end
  end

  assign rdata_o = rdata_q;
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

endmodule

// File: rtl/strm_rx_flowctl.sv
module strm_rx_flowctl #(
  parameter int unsigned CNTW     = 9,
  parameter int unsigned ON_FREE  = 8,
  parameter int unsigned OFF_FREE = 192
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] free_i,
  input  logic            en_i,
  input  logic            pol_i,
  output logic            req_q_o,
  output logic            req_pin_o
);

  localparam logic [CNTW-1:0] ON_LVL  = CNTW'(ON_FREE);
  localparam logic [CNTW-1:0] OFF_LVL = CNTW'(OFF_FREE);

  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (free_i <= ON_LVL) begin
      req_d = 1'b1;
    end else if (free_i >= OFF_LVL) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_q_o   = req_q;
  assign req_pin_o = (en_i && req_q) ? pol_i : ~pol_i;

endmodule

// File: rtl/strm_rx.sv
module strm_rx #(
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned CLK_HALF = 3,
  parameter int unsigned ON_FREE  = 8,
  parameter int unsigned OFF_FREE = 192
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_clk_int,
  input  logic                       cfg_start_pol,
  input  logic                       cfg_valid_pol,
  input  logic                       cfg_req_pol,
  input  logic                       cfg_req_en,
  input  logic                       strm_clk_i,
  output logic                       strm_clk_o,
  output logic                       strm_clk_oe,
  input  logic                       strm_start_i,
  input  logic                       strm_valid_i,
  input  logic [7:0]                 strm_data_i,
  output logic                       strm_req_o,
  input  logic                       rd_en_i,
  output logic [8:0]                 rd_data_o,
  output logic                       rd_empty_o,
  output logic [$clog2(DEPTH+1)-1:0] rd_free_o,
  output logic                       ovf_o,
  input  logic                       ovf_clr_i
);
  import strm_rx_pkg::*;

  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] CAP = CNTW'(DEPTH);

  logic            rst_meta_q;
  logic            rst_sync_n;
  logic            tick;
  logic            cap_push;
  entry_t          cap_entry;
  logic            fifo_full;
  logic [CNTW-1:0] fifo_count;
  logic [CNTW-1:0] free_cnt;
  logic            req_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  strm_rx_clkgen #(
    .CLK_HALF (CLK_HALF)
  ) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_int_i (cfg_clk_int),
    .ext_clk_i (strm_clk_i),
    .tick_o    (tick),
    .clk_o     (strm_clk_o),
    .clk_oe_o  (strm_clk_oe)
  );

  strm_rx_capture #(
    .DATA_W (BYTE_W)
  ) u_capture (
    .tick_i      (tick),
    .start_i     (strm_start_i),
    .valid_i     (strm_valid_i),
    .data_i      (strm_data_i),
    .start_pol_i (cfg_start_pol),
    .valid_pol_i (cfg_valid_pol),
    .push_o      (cap_push),
    .wdata_o     (cap_entry)
  );

  strm_rx_fifo #(
    .WIDTH (ENTRY_W),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_i    (cap_push),
    .wdata_i   (cap_entry),
    .pop_i     (rd_en_i),
    .ovf_clr_i (ovf_clr_i),
    .rdata_o   (rd_data_o),
    .empty_o   (rd_empty_o),
    .full_o    (fifo_full),
    .count_o   (fifo_count),
    .ovf_o     (ovf_o)
  );

  assign free_cnt = CAP - fifo_count;

  strm_rx_flowctl #(
    .CNTW     (CNTW),
    .ON_FREE  (ON_FREE),
    .OFF_FREE (OFF_FREE)
  ) u_flowctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .free_i    (free_cnt),
    .en_i      (cfg_req_en),
    .pol_i     (cfg_req_pol),
    .req_q_o   (req_state),
    .req_pin_o (strm_req_o)
  );

  assign rd_free_o = free_cnt;

endmodule

// File: rtl/strm_rx_chk.sv
module strm_rx_chk #(
  parameter int unsigned CNTW     = 9,
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned ON_FREE  = 8,
  parameter int unsigned OFF_FREE = 192
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CNTW-1:0] free,
  input logic            req_q,
  input logic            req_en,
  input logic            req_pol,
  input logic            req_pin,
  input logic            push,
  input logic            full,
  input logic            ovf,
  input logic            rd_en,
  input logic            empty,
  input logic [8:0]      rd_data
);

  a_r5_req_on: assert property (@(posedge clk) disable iff (!rst_n)
    (free <= CNTW'(ON_FREE)) |=> req_q);

  a_r6_req_off: assert property (@(posedge clk) disable iff (!rst_n)
    (free >= CNTW'(OFF_FREE)) |=> !req_q);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((free > CNTW'(ON_FREE)) && (free < CNTW'(OFF_FREE))) |=> $stable(req_q));

  a_r7_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |-> (req_pin == !req_pol));

  a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf);

  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !push) |=> ($stable(rd_data) && empty));

  a_r8_free_range: assert property (@(posedge clk) disable iff (!rst_n)
    (free <= CNTW'(DEPTH)) && (empty == (free == CNTW'(DEPTH))));

endmodule

bind strm_rx strm_rx_chk #(
  .CNTW     ($clog2(DEPTH + 1)),
  .DEPTH    (DEPTH),
  .ON_FREE  (ON_FREE),
  .OFF_FREE (OFF_FREE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .free    (free_cnt),
  .req_q   (req_state),
  .req_en  (cfg_req_en),
  .req_pol (cfg_req_pol),
  .req_pin (strm_req_o),
  .push    (cap_push),
  .full    (fifo_full),
  .ovf     (ovf_o),
  .rd_en   (rd_en_i),
  .empty   (rd_empty_o),
  .rd_data (rd_data_o)
);

// File: tb/strm_rx_bench.sv
`timescale 1ns/1ps
module strm_rx_bench;

  localparam int DEPTH    = 256;
  localparam int CLK_HALF = 3;

  logic       clk;
  logic       rst_n;
  logic       cfg_clk_int, cfg_start_pol, cfg_valid_pol, cfg_req_pol, cfg_req_en;
  logic       strm_clk_i, strm_start_i, strm_valid_i;
  logic [7:0] strm_data_i;
  logic       strm_clk_o, strm_clk_oe, strm_req_o;
  logic       rd_en_i, ovf_clr_i;
  logic [8:0] rd_data_o;
  logic       rd_empty_o;
  logic [8:0] rd_free_o;
  logic       ovf_o;

  strm_rx #(.DEPTH(DEPTH), .CLK_HALF(CLK_HALF)) u_strm_rx (
    .clk(clk), .rst_n(rst_n),
    .cfg_clk_int(cfg_clk_int), .cfg_start_pol(cfg_start_pol),
    .cfg_valid_pol(cfg_valid_pol), .cfg_req_pol(cfg_req_pol), .cfg_req_en(cfg_req_en),
    .strm_clk_i(strm_clk_i), .strm_clk_o(strm_clk_o), .strm_clk_oe(strm_clk_oe),
    .strm_start_i(strm_start_i), .strm_valid_i(strm_valid_i), .strm_data_i(strm_data_i),
    .strm_req_o(strm_req_o), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .rd_empty_o(rd_empty_o), .rd_free_o(rd_free_o), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference model state
  bit [8:0] mq[$];
  bit       mreq, movf, mlive;
  bit [8:0] mrd;
  bit       m_ext_prev, m_int_prev;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit lvl(bit active, bit pol);
    return active ? pol : ~pol;
  endfunction

  task automatic model_step();
    bit tick, push, pop, valid_act, start_act;
    int free_pre;
    tick = cfg_clk_int ? (strm_clk_o && !m_int_prev) : (strm_clk_i && !m_ext_prev);
    m_int_prev = strm_clk_o;
    m_ext_prev = strm_clk_i;
    valid_act = (strm_valid_i == cfg_valid_pol);
    start_act = (strm_start_i == cfg_start_pol);
    push = tick && valid_act;
    pop  = rd_en_i && (mq.size() > 0);
    free_pre = DEPTH - mq.size();
    if (free_pre <= 8) mreq = 1;
    else if (free_pre >= 192) mreq = 0;
    if (push && mq.size() == DEPTH) movf = 1;
    else if (ovf_clr_i) movf = 0;
    if (pop) mrd = mq.pop_front();
    if (push && free_pre > 0) mq.push_back({start_act, strm_data_i});
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    if (mlive) model_step();
    @(negedge clk);
    if (mlive) begin
      check("R8 rd_data", rd_data_o, mrd);
      check("R8 free", rd_free_o, DEPTH - mq.size());
      check("R8 empty", rd_empty_o, mq.size() == 0);
      check("R9 ovf", ovf_o, movf);
      check("R7 req pin", strm_req_o, lvl(cfg_req_en && mreq, cfg_req_pol));
      check("R2 oe", strm_clk_oe, cfg_clk_int);
    end
  endtask

  task automatic send(bit [7:0] d, bit st, bit vld);
    strm_clk_i   = 1'b0;
    strm_valid_i = lvl(vld, cfg_valid_pol);
    strm_start_i = lvl(st, cfg_start_pol);
    strm_data_i  = d;
    cyc();
    strm_clk_i = 1'b1;
    cyc();
    strm_clk_i   = 1'b0;
    strm_valid_i = lvl(0, cfg_valid_pol);
    strm_start_i = lvl(0, cfg_start_pol);
  endtask

  task automatic pop1();
    rd_en_i = 1'b1;
    cyc();
    rd_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int rises, last_rise, nb;
    rst_n = 1'b0;
    cfg_clk_int = 0; cfg_start_pol = 1; cfg_valid_pol = 1; cfg_req_pol = 1; cfg_req_en = 1;
    strm_clk_i = 0; strm_start_i = 0; strm_valid_i = 0; strm_data_i = '0;
    rd_en_i = 0; ovf_clr_i = 0;
    mlive = 0; mreq = 0; movf = 0; mrd = '0; m_ext_prev = 0; m_int_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mlive = 1;

    // R11 reset state
    check("R11 empty", rd_empty_o, 1);
    check("R11 free", rd_free_o, 256);
    check("R11 ovf", ovf_o, 0);
    check("R11 req", strm_req_o, 0);
    check("R2 oe ext", strm_clk_oe, 0);

    // R1 external capture, R4 tag
    send(8'hA0, 1, 1);
    send(8'hA1, 0, 1);
    send(8'hA2, 0, 1);
    cyc();
    check("R1 free after 3", rd_free_o, 253);
    pop1();
    check("R4 tagged first", rd_data_o, 9'h1A0);
    pop1();
    check("R8 order", rd_data_o, 9'h0A1);
    pop1();
    check("R8 order", rd_data_o, 9'h0A2);
    check("R8 empty", rd_empty_o, 1);

    // R10 pop on empty
    pop1();
    check("R10 data held", rd_data_o, 9'h0A2);
    check("R10 free held", rd_free_o, 256);

    // R3 inverted polarities
    cfg_valid_pol = 0; cfg_start_pol = 0;
    cyc();
    send(8'h55, 0, 0);
    cyc();
    check("R3 inactive valid ignored", rd_free_o, 256);
    send(8'h66, 1, 1);
    cyc();
    check("R3 low-active stored", rd_free_o, 255);
    pop1();
    check("R3 low-active start tag", rd_data_o, 9'h166);
    cfg_valid_pol = 1; cfg_start_pol = 1;
    cyc();

    // R5 fill to threshold
    for (int i = 0; i < 248; i++) send(i[7:0], 0, 1);
    cyc();
    check("R5 req on at free 8", strm_req_o, 1);
    for (int i = 0; i < 8; i++) send(8'hC0 + i[7:0], 0, 1);
    cyc();
    check("R5 eight late bytes kept", rd_free_o, 0);
    check("R9 no ovf yet", ovf_o, 0);
    send(8'hEE, 0, 1);
    cyc();
    check("R9 ovf set", ovf_o, 1);
    check("R9 dropped", rd_free_o, 0);
    ovf_clr_i = 1;
    cyc();
    ovf_clr_i = 0;
    check("R9 ovf cleared", ovf_o, 0);

    // R6 release hysteresis
    for (int i = 0; i < 191; i++) pop1();
    cyc();
    check("R6 still on at free 191", strm_req_o, 1);
    pop1();
    cyc();
    check("R6 off at free 192", strm_req_o, 0);
    send(8'h11, 0, 1);
    cyc();
    check("R6 held off at free 191", strm_req_o, 0);

    // R7 polarity and disable
    cfg_req_pol = 0;
    cyc();
    check("R7 low-active idle", strm_req_o, 1);
    cfg_req_en = 0;
    cyc();
    check("R7 disabled level", strm_req_o, 1);
    cfg_req_en = 1; cfg_req_pol = 1;
    cyc();

    while (!rd_empty_o) pop1();
    check("R8 drained", rd_free_o, 256);

    // R2 internal clock
    cfg_clk_int = 1;
    strm_valid_i = 1;
    strm_start_i = 0;
    rises = 0; last_rise = -1; nb = 0;
    for (int c = 0; c < 60; c++) begin
      bit prev;
      prev = strm_clk_o;
      strm_data_i = c[7:0];
      cyc();
      if (strm_clk_o && !prev) begin
        if (last_rise >= 0) check("R2 period", c - last_rise, 2 * CLK_HALF);
        last_rise = c;
        rises++;
      end
    end
    strm_valid_i = 0;
    cyc();
    check("R2 one byte per rise", rd_free_o, 256 - rises);
    cfg_clk_int = 0;
    cyc();
    check("R2 oe off", strm_clk_oe, 0);
    while (!rd_empty_o) pop1();
    cyc();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule